// File: doc/BRIEF.md
# Guest Interrupt-Command Write Checker

This block sits on the write path of a virtualised interrupt controller. For each guest write it decides, in one cycle, whether hardware can emulate the write directly or must hand it to the hypervisor. There are two kinds of input. The first is a register-style access: a register index, a 64-bit value and a valid strobe. The second is a trap notification: a page offset and a 32-bit word, which is either the recorded command-low value or the current command-high contents.

For each accepted input the block raises exactly one action strobe on the next clock edge. The possible actions are:

- fault
- priority update
- end-of-interrupt
- self-interrupt
- exit
- not handled
- command-high clear

Some actions also carry a shadow-page write: an offset, 32 bits of data, and a flag saying whether the following 32-bit word is zeroed as well. Priority arbitration is done elsewhere.

Top module: `gicw_cmd_check`

## Requirements
- R1: While rst_ni is low, and after it rises with no input strobe, every output is zero.
- R2: A register write to index 0x808 raises fault_o if any value bit 63:8 is set. Otherwise it raises prio_upd_o with prio_val_o equal to value bits 7:0. It also issues a shadow write to offset 0x080 with data equal to that byte and shw_pair_o = 1. This holds whatever the value of vdeliv_en_i.
- R3: With vdeliv_en_i high, a register write to index 0x80B raises fault_o if the value is nonzero, and raises eoi_o otherwise.
- R4: With vdeliv_en_i high, a register write to index 0x83F raises fault_o if any bit 63:8 is set. A vector (bits 7:0) below 16 raises exit_o with exit_off_o = 0x3F0, together with a shadow write to 0x3F0 of the vector with shw_pair_o = 1. A vector of 16 or more raises ipi_o with ipi_vec_o set to that vector.
- R5: A register write to any other index raises only unhandled_o. This also applies to index 0x80B or 0x83F while vdeliv_en_i is low.
- R6: A trap at offset 0x300 raises ipi_o with ipi_vec_o = data[7:0] only when all of the following hold: vdeliv_en_i is high, (data & 0xFFF3B700) is 0, data[19:18] is 01, and data[7:0] ≥ 16. In every other case it raises exit_o with exit_off_o = 0x300.
- R7: A trap at an offset from 0x310 to 0x313 raises hiclr_o and no exit. It comes with a shadow write to 0x310 of data & 0xFF000000, with shw_pair_o = 0.
- R8: A trap at any other offset raises exit_o with exit_off_o equal to that offset.
- R9: The cycle after an input strobe carries exactly one of fault_o, prio_upd_o, eoi_o, ipi_o, exit_o, unhandled_o and hiclr_o. A cycle after no input strobe carries none of them. A data field whose action is not asserted reads zero.
- R10: When reg_valid_i and trap_valid_i are high together, only the register write is served and the trap is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vdeliv_en_i | input | 1 | Virtual interrupt delivery enabled |
| reg_valid_i | input | 1 | Register-style write strobe |
| reg_index_i | input | 12 | Register index |
| reg_value_i | input | 64 | Written value |
| trap_valid_i | input | 1 | Trapped page write strobe |
| trap_offset_i | input | 12 | Page offset of the trapped write |
| trap_data_i | input | 32 | Recorded command-low value or command-high contents |
| fault_o | output | 1 | General-protection fault |
| prio_upd_o | output | 1 | Task-priority update |
| prio_val_o | output | 8 | New task-priority byte |
| eoi_o | output | 1 | End-of-interrupt command |
| ipi_o | output | 1 | Self-interrupt command |
| ipi_vec_o | output | 8 | Self-interrupt vector |
| exit_o | output | 1 | Exit to the hypervisor |
| exit_off_o | output | 12 | Register offset reported with the exit |
| unhandled_o | output | 1 | Index not handled here |
| hiclr_o | output | 1 | Command-high low 24 bits cleared |
| shw_o | output | 1 | Shadow-page write |
| shw_pair_o | output | 1 | Also zero the following 32-bit word |
| shw_off_o | output | 12 | Shadow write offset |
| shw_data_o | output | 32 | Shadow write data |

## Verification
The assertions watch the following on every cycle:

- The one-strobe-per-input timing.
- Silence after idle cycles.
- A self-interrupt never carries a vector below 16.
- A command-high clear always comes with a masked, unpaired shadow write.
- End-of-interrupt never appears without delivery enabled.
- Faults come only from register writes.
- A simultaneous trap is dropped.

Only the bench's sweeps can show that the decode is right. These cover every vector across the index and trap paths, every single-bit corruption of the command word and of the upper value bits, and the byte range around the command-high register. Each sweep is compared against an arithmetic model of the requirements.

// File: rtl/gicw_pkg.sv
package gicw_pkg;
  parameter int IDX_W = 12;
  parameter int OFF_W = 12;
  parameter int VAL_W = 64;
  parameter int CMD_W = 32;
  parameter int VEC_W = 8;
  parameter int MIN_VEC = 16;
  parameter int SH_LSB = 18;

  localparam logic [IDX_W-1:0] IDX_PRIO = 12'h808;
  localparam logic [IDX_W-1:0] IDX_EOI  = 12'h80B;
  localparam logic [IDX_W-1:0] IDX_SELF = 12'h83F;

  localparam logic [OFF_W-1:0] OFF_PRIO  = 12'h080;
  localparam logic [OFF_W-1:0] OFF_CMDLO = 12'h300;
  localparam logic [OFF_W-1:0] OFF_CMDHI = 12'h310;
  localparam logic [OFF_W-1:0] OFF_SELF  = 12'h3F0;

  localparam logic [CMD_W-1:0] CMD_RSVD_MASK = 32'hFFF3_B700;
  localparam logic [CMD_W-1:0] CMDHI_KEEP    = 32'hFF00_0000;
  localparam logic [1:0]       SH_SELF       = 2'b01;

  typedef enum logic [2:0] {
    ACT_NONE, ACT_FAULT, ACT_PRIO, ACT_EOI, ACT_IPI, ACT_EXIT, ACT_UNH, ACT_HICLR
  } act_e;

  typedef struct packed {
    act_e             act;
    logic [VEC_W-1:0] vec;
    logic [OFF_W-1:0] exit_off;
    logic             shw;
    logic             shw_pair;
    logic [OFF_W-1:0] shw_off;
    logic [CMD_W-1:0] shw_data;
  } res_t;

  localparam res_t RES_IDLE = '{act: ACT_NONE, default: '0};
endpackage

// File: rtl/gicw_reg_decode.sv
module gicw_reg_decode
  import gicw_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  input  logic [VAL_W-1:0] val_i,
  input  logic             en_i,
  output res_t             res_o
);
  logic             hi_nz;
  logic [VEC_W-1:0] vec;

  assign hi_nz = |val_i[VAL_W-1:VEC_W];
  assign vec   = val_i[VEC_W-1:0];

  always_comb begin
    res_o = RES_IDLE;
    if (idx_i == IDX_PRIO) begin
      if (hi_nz) res_o.act = ACT_FAULT;
      else begin
        res_o.act      = ACT_PRIO;
        res_o.vec      = vec;
        res_o.shw      = 1'b1;
        res_o.shw_pair = 1'b1;
        res_o.shw_off  = OFF_PRIO;
        res_o.shw_data = CMD_W'(vec);
      end
    end else if (en_i && idx_i == IDX_EOI) begin
      res_o.act = (|val_i) ? ACT_FAULT : ACT_EOI;
    end else if (en_i && idx_i == IDX_SELF) begin
      if (hi_nz) res_o.act = ACT_FAULT;
      else if (int'(vec) < MIN_VEC) begin
        // low vectors are recorded and left to the hypervisor
        res_o.act      = ACT_EXIT;
        res_o.exit_off = OFF_SELF;
        res_o.shw      = 1'b1;
        res_o.shw_pair = 1'b1;
        res_o.shw_off  = OFF_SELF;
        res_o.shw_data = CMD_W'(vec);
      end else begin
        res_o.act = ACT_IPI;
        res_o.vec = vec;
      end
    end else begin
      res_o.act = ACT_UNH;
    end
  end
endmodule

// File: rtl/gicw_trap_decode.sv
module gicw_trap_decode
  import gicw_pkg::*;
(
  input  logic [OFF_W-1:0] off_i,
  input  logic [CMD_W-1:0] data_i,
  input  logic             en_i,
  output res_t             res_o
);
  logic in_hi, cmd_ok;

  assign in_hi  = off_i[OFF_W-1:2] == OFF_CMDHI[OFF_W-1:2];
  assign cmd_ok = en_i && ((data_i & CMD_RSVD_MASK) == '0)
               && (data_i[SH_LSB+1:SH_LSB] == SH_SELF)
               && (int'(data_i[VEC_W-1:0]) >= MIN_VEC);

  always_comb begin
    res_o = RES_IDLE;
    if (in_hi) begin
      res_o.act      = ACT_HICLR;
      res_o.shw      = 1'b1;
      res_o.shw_off  = OFF_CMDHI;
      res_o.shw_data = data_i & CMDHI_KEEP;
    end else if (off_i == OFF_CMDLO && cmd_ok) begin
      res_o.act = ACT_IPI;
      res_o.vec = data_i[VEC_W-1:0];
    end else begin
      res_o.act      = ACT_EXIT;
      res_o.exit_off = off_i;
    end
  end
endmodule

// File: rtl/gicw_cmd_check.sv
module gicw_cmd_check
  import gicw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vdeliv_en_i,
  input  logic             reg_valid_i,
  input  logic [IDX_W-1:0] reg_index_i,
  input  logic [VAL_W-1:0] reg_value_i,
  input  logic             trap_valid_i,
  input  logic [OFF_W-1:0] trap_offset_i,
  input  logic [CMD_W-1:0] trap_data_i,
  output logic             fault_o,
  output logic             prio_upd_o,
  output logic [VEC_W-1:0] prio_val_o,
  output logic             eoi_o,
  output logic             ipi_o,
  output logic [VEC_W-1:0] ipi_vec_o,
  output logic             exit_o,
  output logic [OFF_W-1:0] exit_off_o,
  output logic             unhandled_o,
  output logic             hiclr_o,
  output logic             shw_o,
  output logic             shw_pair_o,
  output logic [OFF_W-1:0] shw_off_o,
  output logic [CMD_W-1:0] shw_data_o
);
  res_t reg_res, trap_res, res_d, res_q;

  gicw_reg_decode u_reg (
    .idx_i(reg_index_i), .val_i(reg_value_i), .en_i(vdeliv_en_i), .res_o(reg_res)
  );
  gicw_trap_decode u_trap (
    .off_i(trap_offset_i), .data_i(trap_data_i), .en_i(vdeliv_en_i), .res_o(trap_res)
  );

  // register path wins over a coincident trap
  always_comb begin
    if (reg_valid_i)       res_d = reg_res;
    else if (trap_valid_i) res_d = trap_res;
    else                   res_d = RES_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_q <= RES_IDLE;
    else         res_q <= res_d;
  end

  assign fault_o     = res_q.act == ACT_FAULT;
  assign prio_upd_o  = res_q.act == ACT_PRIO;
  assign eoi_o       = res_q.act == ACT_EOI;
  assign ipi_o       = res_q.act == ACT_IPI;
  assign exit_o      = res_q.act == ACT_EXIT;
  assign unhandled_o = res_q.act == ACT_UNH;
  assign hiclr_o     = res_q.act == ACT_HICLR;
  assign prio_val_o  = prio_upd_o ? res_q.vec : '0;
  assign ipi_vec_o   = ipi_o ? res_q.vec : '0;
  assign exit_off_o  = res_q.exit_off;
  assign shw_o       = res_q.shw;
  assign shw_pair_o  = res_q.shw_pair;
  assign shw_off_o   = res_q.shw_off;
  assign shw_data_o  = res_q.shw_data;

  logic [6:0] strobes;
  assign strobes = {fault_o, prio_upd_o, eoi_o, ipi_o, exit_o, unhandled_o, hiclr_o};

  assert_one_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_valid_i || trap_valid_i) |=> $countones(strobes) == 1);
  assert_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_valid_i || trap_valid_i) |=> strobes == '0);
  assert_ipi_vec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ipi_o |-> int'(ipi_vec_o) >= MIN_VEC);
  assert_hiclr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hiclr_o |-> shw_o && !shw_pair_o && shw_off_o == OFF_CMDHI && shw_data_o[23:0] == '0);
  assert_eoi_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_valid_i && !vdeliv_en_i) |=> !eoi_o);
  assert_fault_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_valid_i) |=> !fault_o);
  assert_trap_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_valid_i && trap_valid_i) |=> !hiclr_o);
endmodule

// File: tb/gicw_cmd_check_test.sv
`timescale 1ns/1ps
module gicw_cmd_check_test;
  logic clk = 0, rst_n = 0;
  logic en = 0, rv = 0, tv = 0;
  logic [11:0] ridx = 0, toff = 0;
  logic [63:0] rval = 0;
  logic [31:0] tdat = 0;
  logic fault, pupd, eoi, ipi, ex, unh, hic, shw, shwp;
  logic [7:0] pval, ivec;
  logic [11:0] exoff, shwoff;
  logic [31:0] shwd;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  gicw_cmd_check uut (
    .clk_i(clk), .rst_ni(rst_n), .vdeliv_en_i(en),
    .reg_valid_i(rv), .reg_index_i(ridx), .reg_value_i(rval),
    .trap_valid_i(tv), .trap_offset_i(toff), .trap_data_i(tdat),
    .fault_o(fault), .prio_upd_o(pupd), .prio_val_o(pval), .eoi_o(eoi),
    .ipi_o(ipi), .ipi_vec_o(ivec), .exit_o(ex), .exit_off_o(exoff),
    .unhandled_o(unh), .hiclr_o(hic), .shw_o(shw), .shw_pair_o(shwp),
    .shw_off_o(shwoff), .shw_data_o(shwd)
  );

  // {fault,prio,eoi,ipi,exit,unh,hiclr, prio_val, ipi_vec, exit_off, shw, pair, shw_off, shw_data}
  function automatic logic [80:0] pack(logic [6:0] s, logic [7:0] pv, logic [7:0] iv,
      logic [11:0] eo, logic w, logic p, logic [11:0] wo, logic [31:0] wd);
    return {s, pv, iv, eo, w, p, wo, wd};
  endfunction

  function automatic logic [80:0] got();
    return pack({fault, pupd, eoi, ipi, ex, unh, hic}, pval, ivec, exoff, shw, shwp, shwoff, shwd);
  endfunction

  function automatic logic [80:0] exp_reg(logic [11:0] i, logic [63:0] v, logic e);
    logic hi = v[63:8] != 0;
    if (i == 12'h808) begin
      if (hi) return pack(7'b1000000, 0, 0, 0, 0, 0, 0, 0);
      return pack(7'b0100000, v[7:0], 0, 0, 1, 1, 12'h080, {24'h0, v[7:0]});
    end
    if (e && i == 12'h80B)
      return (v != 0) ? pack(7'b1000000, 0, 0, 0, 0, 0, 0, 0) : pack(7'b0010000, 0, 0, 0, 0, 0, 0, 0);
    if (e && i == 12'h83F) begin
      if (hi) return pack(7'b1000000, 0, 0, 0, 0, 0, 0, 0);
      if (v[7:0] < 16) return pack(7'b0000100, 0, 0, 12'h3F0, 1, 1, 12'h3F0, {24'h0, v[7:0]});
      return pack(7'b0001000, 0, v[7:0], 0, 0, 0, 0, 0);
    end
    return pack(7'b0000010, 0, 0, 0, 0, 0, 0, 0);
  endfunction

  function automatic logic [80:0] exp_trap(logic [11:0] o, logic [31:0] d, logic e);
    if (o >= 12'h310 && o <= 12'h313)
      return pack(7'b0000001, 0, 0, 0, 1, 0, 12'h310, {d[31:24], 24'h0});
    if (o == 12'h300 && e && (d & 32'hFFF3B700) == 0 && d[19:18] == 2'b01 && d[7:0] >= 16)
      return pack(7'b0001000, 0, d[7:0], 0, 0, 0, 0, 0);
    return pack(7'b0000100, 0, 0, o, 0, 0, 0, 0);
  endfunction

  task automatic cmp(string req, logic [80:0] e);
    logic [80:0] g = got();
    checks++;
    if (g !== e) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, g, e);
    end
  endtask

  task automatic do_reg(string req, logic [11:0] i, logic [63:0] v, logic e);
    @(negedge clk); en = e; ridx = i; rval = v; rv = 1;
    @(negedge clk); rv = 0;
    cmp(req, exp_reg(i, v, e));
  endtask

  task automatic do_trap(string req, logic [11:0] o, logic [31:0] d, logic e);
    @(negedge clk); en = e; toff = o; tdat = d; tv = 1;
    @(negedge clk); tv = 0;
    cmp(req, exp_trap(o, d, e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1 in reset", '0);
    rst_n = 1;
    @(negedge clk);
    cmp("R1 after reset", '0);

    // R2 priority index, both enables
    for (int e = 0; e < 2; e++)
      for (int v = 0; v < 256; v++) do_reg("R2 prio", 12'h808, 64'(v), e[0]);
    for (int k = 8; k < 64; k++) do_reg("R2 prio fault", 12'h808, (64'd1 << k) | 64'h5A, 1'b1);

    // R3 EOI
    do_reg("R3 eoi", 12'h80B, 0, 1'b1);
    for (int k = 0; k < 64; k++) do_reg("R3 eoi fault", 12'h80B, 64'd1 << k, 1'b1);

    // R4 self-interrupt index
    for (int v = 0; v < 256; v++) do_reg("R4 self", 12'h83F, 64'(v), 1'b1);
    for (int k = 8; k < 64; k++) do_reg("R4 self fault", 12'h83F, (64'd1 << k) | 64'h20, 1'b1);

    // R5 other indices and disabled delivery
    do_reg("R5 eoi disabled", 12'h80B, 0, 1'b0);
    do_reg("R5 eoi disabled nz", 12'h80B, 64'hFFFF, 1'b0);
    do_reg("R5 self disabled", 12'h83F, 64'h40, 1'b0);
    for (int i = 12'h800; i < 12'h840; i++)
      if (i != 12'h808 && i != 12'h80B && i != 12'h83F) do_reg("R5 other", 12'(i), 64'hDEAD_0000_0000_BEEF, 1'b1);

    // R6 command-low trap
    for (int e = 0; e < 2; e++)
      for (int v = 0; v < 256; v++) do_trap("R6 cmdlo vec", 12'h300, (32'd1 << 18) | 32'(v), e[0]);
    for (int s = 0; s < 4; s++) do_trap("R6 cmdlo shorthand", 12'h300, (32'(s) << 18) | 32'h40, 1'b1);
    for (int k = 8; k < 32; k++) do_trap("R6 cmdlo bit", 12'h300, (32'd1 << 18) | 32'h40 | (32'd1 << k), 1'b1);

    // R7 command-high range and neighbours
    for (int o = 12'h30C; o < 12'h318; o++) do_trap("R7 cmdhi", 12'(o), 32'hA5C3_7E19, 1'b1);

    // R8 other offsets
    for (int o = 0; o < 12'h400; o += 12'h34) do_trap("R8 other", 12'(o), 32'h0004_0050, 1'b1);
    do_trap("R8 self offset", 12'h3F0, 32'h0, 1'b1);

    // R9 idle cycle after a strobe
    do_reg("R9 lead", 12'h808, 64'h33, 1'b1);
    @(negedge clk);
    cmp("R9 idle", '0);

    // R10 coincident strobes
    @(negedge clk); en = 1; ridx = 12'h80B; rval = 0; rv = 1; toff = 12'h310; tdat = 32'hFFFF_FFFF; tv = 1;
    @(negedge clk); rv = 0; tv = 0;
    cmp("R10 both", exp_reg(12'h80B, 0, 1'b1));
    @(negedge clk);
    cmp("R10 dropped", '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule